// File: doc/BRIEF.md
# Triggered Cyclic Waveform Player

The block holds a waveform that a host loads over a simple command port, and plays it back endlessly toward a DAC once triggered. A count command fixes how many points the waveform has. Data commands then fill a synchronous on-chip sample array from address zero upward. Once the last point is stored, the controller reads the start of the waveform into a dual-clock output FIFO until the FIFO is full, and then reports that it is ready.

A trigger command starts playback. In the sample clock domain, each sample clock pops one word from the FIFO into the output register that drives the DAC. In the system domain, the controller refills the FIFO from the array whenever it holds less than half its depth. The read address wraps from the last programmed point back to point zero, so the output repeats with no break. A stop input ends playback, drains the FIFO and repeats the preload. If the FIFO runs dry, a sticky underrun flag is raised. Commands that arrive at the wrong time are dropped and raise a sticky error flag.

Top module: `wave_player`

## Requirements
- R1: After reset, dac_out is 0, and playing, ready, cmd_err and underrun are all 0. fifo_empty is 1.
- R2: A count command (cmd_op = 2'b01) sets the point count to cmd_data, limited to the array depth (64 by default), and clears cmd_err. The data commands that follow (cmd_op = 2'b10) fill addresses 0, 1, 2 and so on, in order.
- R3: When the last programmed point has been stored, the FIFO is filled to full and ready rises. dac_out does not change before a trigger.
- R4: A trigger (cmd_op = 2'b11) while ready starts playback. dac_out shows point 0, then point 1, and so on, one new point per sample clock, with no repeat and no gap.
- R5: After the last programmed point, the next sample is point 0 again. This also holds for a one-point waveform and for the full array depth.
- R6: The FIFO never overflows. While ready, fifo_full and fifo_half are 1 and fifo_empty is 0. During playback, refills keep pace with any sample clock slower than the system clock.
- R7: If the FIFO is empty during playback, underrun is set and dac_out holds. underrun stays set until the next trigger starts playback.
- R8: A stop pulse during playback clears playing, drains the FIFO and repeats the preload until ready rises again. The next trigger restarts at point 0.
- R9: A trigger while the point count is 0, or while not ready, leaves playing at 0.
- R10: A data command during playback, or one beyond the programmed count, does not change the stored waveform and sets cmd_err.
- R11: A count command during playback leaves the point count and the playback unchanged and sets cmd_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock (controller, array, FIFO write side) |
| sys_rst_n | input | 1 | Synchronous active-low reset, system domain |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 2 | Command code: 01 count, 10 data, 11 trigger, 00 none |
| cmd_data | input | 16 | Point count or sample word |
| stop | input | 1 | Ends playback when high during playback |
| playing | output | 1 | Playback active |
| ready | output | 1 | Preload complete, trigger accepted |
| cmd_err | output | 1 | Sticky: a command was discarded |
| fifo_full | output | 1 | FIFO full (write-side view) |
| fifo_half | output | 1 | FIFO at least half full (write-side view) |
| fifo_empty | output | 1 | FIFO empty (write-side view) |
| smp_clk | input | 1 | Sample clock |
| smp_rst_n | input | 1 | Synchronous active-low reset, sample domain |
| dac_out | output | 16 | Output register to the DAC |
| underrun | output | 1 | Sticky: FIFO ran dry during playback |

## Verification
A wrong read address or a wrong wrap point shows up as a wrong dac_out word within one sample clock of the fault. The bench checks every sample against the expected point index, so a gap or a repeated word shows up at once. If the refill accounting is wrong, the FIFO overflows during preload or ready never rises, which is visible within a few dozen system cycles of the last data word. A flush handshake that drops or leaks stale words shows up as a first sample after the stop that is not point 0. A sticky flag that was not kept or not cleared is visible on the next status read around a trigger.

// File: rtl/wp_pkg.sv
// Shared types for the waveform player.
// Assumes one command per system cycle, coded in two bits.
package wp_pkg;

    localparam logic [1:0] OP_NONE  = 2'b00;
    localparam logic [1:0] OP_COUNT = 2'b01;
    localparam logic [1:0] OP_DATA  = 2'b10;
    localparam logic [1:0] OP_TRIG  = 2'b11;

    typedef enum logic [2:0] {
        ST_LOAD,
        ST_PREFETCH,
        ST_READY,
        ST_PLAY,
        ST_FLUSH,
        ST_UNFLUSH
    } ctrl_state_t;

endpackage

// File: rtl/wp_sync.sv
// Two-flop synchroniser, one bit per lane.
// Assumes the input is a register in the source domain (no glitches),
// and that multi-bit inputs change at most one bit at a time (Gray code).
module wp_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    // Two register stages into the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/wp_sample_mem.sv
// Single-clock sample array: one write port and one synchronous read port.
// The read data is valid the cycle after re. Holds no reset state.
module wp_sample_mem #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (re) rdata <= store[raddr];
    end

endmodule

// File: rtl/wp_gray_fifo.sv
// Dual-clock FIFO with Gray-coded pointers, each synchronised by two flops.
// The write side reports its level and the full, half and empty flags from
// a delayed copy of the read pointer, so these flags are pessimistic. The
// read side sees empty from a delayed write pointer. Depth is 2**AW.
// Assumes the writer never writes when full and the reader never pops when empty.
module wp_gray_fifo #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [AW:0]   level,
    output logic          full,
    output logic          half,
    output logic          empty_w,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty
);

    localparam int PW = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_LVL = PW'(DEPTH / 2);

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [DW-1:0] cells [DEPTH];
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] rgray_w, wgray_r;

    // Advance the write pointer on each accepted word.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_en) begin
            wbin  <= wbin + PW'(1);
            wgray <= to_gray(wbin + PW'(1));
        end
    end

    // Store the word at the write slot.
    always_ff @(posedge wclk) begin
        if (wr_en) cells[wbin[AW-1:0]] <= wr_data;
    end

    // Advance the read pointer on each pop.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (rd_en) begin
            rbin  <= rbin + PW'(1);
            rgray <= to_gray(rbin + PW'(1));
        end
    end

    wp_sync #(.W(PW)) u_rptr_sync (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w));
    wp_sync #(.W(PW)) u_wptr_sync (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r));

    assign level   = wbin - from_gray(rgray_w);
    assign full    = (level == FULL_LVL);
    assign half    = (level >= HALF_LVL);
    assign empty_w = (level == '0);
    assign empty   = (rgray == wgray_r);
    assign rd_data = cells[rbin[AW-1:0]];

    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
        wr_en |-> !full);  // R6
    AST_LEVEL_RANGE: assert property (@(posedge wclk) disable iff (!wrst_n)
        level <= FULL_LVL);  // R6
    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rrst_n)
        rd_en |-> !empty);  // R7

endmodule

// File: rtl/wp_ctrl.sv
// Playback controller in the system clock domain. It decodes commands,
// writes the sample array, preloads and refills the FIFO, and wraps the
// read address at the point count. It also runs the drain handshake with
// the sample domain. A read issued in one cycle lands in the FIFO on the
// next, so the refill limit counts that read as already in the FIFO.
module wp_ctrl
    import wp_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DW      = 16,
    parameter int FIFO_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [DW-1:0]     cmd_data,
    input  logic              stop,
    input  logic [FIFO_AW:0]  fifo_level,
    input  logic              fifo_full,
    input  logic              fifo_empty_w,
    input  logic              flush_ack,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DW-1:0]     mem_wdata,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              fifo_we,
    output logic              flush_req,
    output logic              playing,
    output logic              ready,
    output logic              cmd_err
);

    localparam int CW = ADDR_W + 1;
    localparam int OW = FIFO_AW + 2;
    localparam int MEM_DEPTH = 1 << ADDR_W;
    localparam int FDEPTH = 1 << FIFO_AW;
    localparam logic [DW-1:0] DEPTH_D = DW'(MEM_DEPTH);
    localparam logic [OW-1:0] OCC_FULL = OW'(FDEPTH);
    localparam logic [OW-1:0] OCC_HALF = OW'(FDEPTH / 2);

    ctrl_state_t state, state_d;
    logic [CW-1:0]     count, wr_idx, clip_cnt;
    logic [ADDR_W-1:0] rd_addr;
    logic              pend;
    logic [OW-1:0]     occ;
    logic              is_set, is_wr, is_trig;
    logic              set_ok, wr_ok, bad_cmd, issue, wrap;

    assign is_set  = cmd_valid && (cmd_op == OP_COUNT);
    assign is_wr   = cmd_valid && (cmd_op == OP_DATA);
    assign is_trig = cmd_valid && (cmd_op == OP_TRIG);
    assign set_ok  = is_set && (state != ST_PLAY);
    assign wr_ok   = is_wr && (state != ST_PLAY) && (wr_idx < count);
    assign bad_cmd = (is_wr && !wr_ok) || (is_set && !set_ok);
    assign clip_cnt = (cmd_data > DEPTH_D) ? CW'(MEM_DEPTH) : CW'(cmd_data);

    assign occ  = {1'b0, fifo_level} + OW'(pend);
    assign wrap = ({1'b0, rd_addr} == (count - CW'(1)));
    assign issue = ((state == ST_PREFETCH) && (occ < OCC_FULL)) ||
                   ((state == ST_PLAY) && (occ < OCC_HALF));

    // Next-state selection; a count command outside playback restarts loading.
    always_comb begin
        state_d = state;
        unique case (state)
            ST_LOAD:     if (wr_idx == count && count != '0) state_d = ST_PREFETCH;
            ST_PREFETCH: if (fifo_full && !pend) state_d = ST_READY;
            ST_READY:    if (is_trig) state_d = ST_PLAY;
            ST_PLAY:     if (stop) state_d = ST_FLUSH;
            ST_FLUSH:    if (fifo_empty_w && flush_ack && !pend) state_d = ST_UNFLUSH;
            ST_UNFLUSH:  if (!flush_ack) state_d = ST_LOAD;
            default:     state_d = ST_LOAD;
        endcase
        if (set_ok) state_d = ST_FLUSH;
    end

    // State and registered status toward both domains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_LOAD;
            playing   <= 1'b0;
            ready     <= 1'b0;
            flush_req <= 1'b0;
        end else begin
            state     <= state_d;
            playing   <= (state_d == ST_PLAY);
            ready     <= (state_d == ST_READY);
            flush_req <= (state_d == ST_FLUSH);
        end
    end

    // Point count, write index and the sticky command error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            wr_idx  <= '0;
            cmd_err <= 1'b0;
        end else begin
            if (set_ok) begin
                count   <= clip_cnt;
                wr_idx  <= '0;
                cmd_err <= 1'b0;
            end else if (wr_ok) begin
                wr_idx <= wr_idx + CW'(1);
            end
            if (bad_cmd) cmd_err <= 1'b1;
        end
    end

    // Read address with wrap at the count, plus the read-in-flight marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr <= '0;
            pend    <= 1'b0;
        end else begin
            pend <= issue;
            if (state == ST_UNFLUSH) rd_addr <= '0;
            else if (issue) rd_addr <= wrap ? '0 : rd_addr + ADDR_W'(1);
        end
    end

    assign mem_we    = wr_ok;
    assign mem_waddr = wr_idx[ADDR_W-1:0];
    assign mem_wdata = cmd_data;
    assign mem_re    = issue;
    assign mem_raddr = rd_addr;
    assign fifo_we   = pend;

    AST_ZERO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (is_trig && count == '0) |=> !playing);  // R9
    AST_PLAY_DATA_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && playing) |=> cmd_err);  // R10
    AST_PLAY_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_set && playing) |=> ($stable(count) && cmd_err));  // R11
    AST_READ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> ({1'b0, mem_raddr} < count));  // R5
    AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> fifo_full);  // R3

endmodule

// File: rtl/wp_out_stage.sv
// Sample-domain side: synchronises the play and drain requests, pops the
// FIFO into the DAC register, and keeps the sticky underrun flag. While a
// drain is requested, words are popped and discarded and the register holds.
module wp_out_stage #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          play_req,
    input  logic          flush_req,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_data,
    output logic          fifo_re,
    output logic          flush_seen,
    output logic [DW-1:0] dac_out,
    output logic          underrun
);

    logic [1:0] req_s;
    logic       play_s, play_d, play_rise, live;

    wp_sync #(.W(2)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .d({flush_req, play_req}), .q(req_s)
    );

    assign play_s     = req_s[0];
    assign flush_seen = req_s[1];
    assign live       = play_s && !flush_seen;
    assign play_rise  = play_s && !play_d;
    assign fifo_re    = (play_s || flush_seen) && !fifo_empty;

    // Output register update and sticky underrun bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            play_d   <= 1'b0;
            dac_out  <= '0;
            underrun <= 1'b0;
        end else begin
            play_d <= play_s;
            if (live && !fifo_empty) dac_out <= fifo_data;
            if (play_rise) underrun <= 1'b0;
            else if (live && fifo_empty) underrun <= 1'b1;
        end
    end

    AST_HOLD_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (live && fifo_empty) |=> $stable(dac_out));  // R7
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !live |=> $stable(dac_out));  // R3

endmodule

// File: rtl/wave_player.sv
// Top level of the triggered cyclic waveform player. The system domain
// holds the controller, the sample array and the FIFO write side. The
// sample domain holds the FIFO read side and the DAC register. Each domain
// has its own synchronous active-low reset, and both resets are assumed to
// be asserted together while both clocks run.
module wave_player #(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 6,
    parameter int FIFO_AW = 4
) (
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              stop,
    output logic              playing,
    output logic              ready,
    output logic              cmd_err,
    output logic              fifo_full,
    output logic              fifo_half,
    output logic              fifo_empty,
    input  logic              smp_clk,
    input  logic              smp_rst_n,
    output logic [DATA_W-1:0] dac_out,
    output logic              underrun
);

    logic              mem_we, mem_re, fifo_we, flush_req, flush_seen, flush_ack;
    logic              fifo_re, rd_empty;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata, fifo_rdata;
    logic [FIFO_AW:0]  fifo_level;

    wp_sample_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk(sys_clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .re(mem_re), .raddr(mem_raddr), .rdata(mem_rdata)
    );

    wp_gray_fifo #(.DW(DATA_W), .AW(FIFO_AW)) u_fifo (
        .wclk(sys_clk), .wrst_n(sys_rst_n), .wr_en(fifo_we), .wr_data(mem_rdata),
        .level(fifo_level), .full(fifo_full), .half(fifo_half), .empty_w(fifo_empty),
        .rclk(smp_clk), .rrst_n(smp_rst_n), .rd_en(fifo_re), .rd_data(fifo_rdata),
        .empty(rd_empty)
    );

    wp_ctrl #(.ADDR_W(ADDR_W), .DW(DATA_W), .FIFO_AW(FIFO_AW)) u_ctrl (
        .clk(sys_clk), .rst_n(sys_rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .stop(stop), .fifo_level(fifo_level),
        .fifo_full(fifo_full), .fifo_empty_w(fifo_empty), .flush_ack(flush_ack),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_raddr(mem_raddr), .fifo_we(fifo_we),
        .flush_req(flush_req), .playing(playing), .ready(ready), .cmd_err(cmd_err)
    );

    wp_sync #(.W(1)) u_ack_sync (
        .clk(sys_clk), .rst_n(sys_rst_n), .d(flush_seen), .q(flush_ack)
    );

    wp_out_stage #(.DW(DATA_W)) u_out (
        .clk(smp_clk), .rst_n(smp_rst_n), .play_req(playing), .flush_req(flush_req),
        .fifo_empty(rd_empty), .fifo_data(fifo_rdata), .fifo_re(fifo_re),
        .flush_seen(flush_seen), .dac_out(dac_out), .underrun(underrun)
    );

endmodule

// File: tb/tb_wave_player.sv
`timescale 1ns/1ps
module tb_wave_player;

    localparam int MEMD = 64;
    localparam logic [1:0] C_CNT = 2'b01, C_DAT = 2'b10, C_TRG = 2'b11;
    // Each vector: {count command, first sample, step between samples}
    localparam logic [47:0] VEC [5] = '{
        {16'd1,   16'h1111, 16'h0000},
        {16'd3,   16'h2000, 16'h0101},
        {16'd5,   16'h8001, 16'hF00F},
        {16'd20,  16'h3000, 16'h0011},
        {16'd100, 16'h4000, 16'h0203}
    };

    logic clk = 1'b0, smp_clk = 1'b0;
    logic sys_rst_n = 1'b0, smp_rst_n = 1'b0;
    logic cmd_valid = 1'b0, stop = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [15:0] cmd_data = '0;
    logic playing, ready, cmd_err, fifo_full, fifo_half, fifo_empty, underrun;
    logic [15:0] dac_out;
    int n_checks = 0, n_fail = 0;
    int smp_half = 20;
    bit done = 1'b0;

    wave_player dut (
        .sys_clk(clk), .sys_rst_n(sys_rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .stop(stop), .playing(playing), .ready(ready),
        .cmd_err(cmd_err), .fifo_full(fifo_full), .fifo_half(fifo_half),
        .fifo_empty(fifo_empty), .smp_clk(smp_clk), .smp_rst_n(smp_rst_n),
        .dac_out(dac_out), .underrun(underrun)
    );

    always #4 clk = ~clk;
    initial forever #(smp_half) smp_clk = ~smp_clk;

    function automatic logic [15:0] wv(input logic [15:0] b, input logic [15:0] s, input int i);
        return b + 16'(32'(s) * i);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] op, input logic [15:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
    endtask

    task automatic load(input int cnt, input int nwr, input logic [15:0] b, input logic [15:0] s);
        send(C_CNT, 16'(cnt));
        for (int i = 0; i < nwr; i++) send(C_DAT, wv(b, s, i));
    endtask

    task automatic wait_ready(input string tag);
        for (int i = 0; i < 4000 && !ready; i++) @(negedge clk);
        chk(tag, 32'(ready), 32'd1);
    endtask

    task automatic do_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 playing low after stop", 32'(playing), 32'd0);
    endtask

    // Trigger, find the first fresh sample, then follow the cyclic sequence.
    task automatic run_check(input int n, input logic [15:0] b, input logic [15:0] s, input string tag);
        logic [15:0] h, v;
        int k0;
        bit seen;
        @(negedge smp_clk);
        h = dac_out;
        send(C_TRG, 16'h0);
        seen = 1'b0;
        for (int i = 0; i < 200 && !seen; i++) begin
            @(negedge smp_clk);
            if (dac_out !== h) seen = 1'b1;
        end
        v = dac_out;
        k0 = -1;
        if (v == wv(b, s, 0)) k0 = 0;
        else if (h == wv(b, s, 0) && n > 1 && v == wv(b, s, 1)) k0 = 1;
        chk({tag, " R4 first sample is point 0"}, 32'(k0 >= 0), 32'd1);
        if (k0 < 0) return;
        for (int j = 1; j <= 2 * n + 2; j++) begin
            @(negedge smp_clk);
            chk({tag, " R5 cyclic sample"}, 32'(dac_out), 32'(wv(b, s, (k0 + j) % n)));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] hold;
        repeat (20) @(negedge clk);
        sys_rst_n = 1'b1; smp_rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 dac_out", 32'(dac_out), 32'd0);
        chk("R1 playing", 32'(playing), 32'd0);
        chk("R1 ready", 32'(ready), 32'd0);
        chk("R1 cmd_err", 32'(cmd_err), 32'd0);
        chk("R1 underrun", 32'(underrun), 32'd0);
        chk("R1 fifo_empty", 32'(fifo_empty), 32'd1);
        // R9 trigger with zero count
        send(C_TRG, 16'h0);
        repeat (10) @(negedge clk);
        chk("R9 trigger at count 0", 32'(playing), 32'd0);

        // Table of waveforms walked by one loop
        for (int v = 0; v < 5; v++) begin
            int cnt, n;
            logic [15:0] b, s;
            cnt = int'(VEC[v][47:32]); b = VEC[v][31:16]; s = VEC[v][15:0];
            n = (cnt > MEMD) ? MEMD : cnt;
            hold = dac_out;
            load(cnt, n, b, s);
            wait_ready("R3 ready after load (R2 clip)");
            chk("R3 dac unchanged before trigger", 32'(dac_out), 32'(hold));
            chk("R6 full while ready", 32'(fifo_full), 32'd1);
            chk("R6 half while ready", 32'(fifo_half), 32'd1);
            chk("R6 not empty while ready", 32'(fifo_empty), 32'd0);
            chk("R2 cmd_err clear", 32'(cmd_err), 32'd0);
            run_check(n, b, s, "table");
            do_stop();
            wait_ready("R8 preload repeated after stop");
        end

        // R10 and R11 during playback, then replay proves nothing changed
        load(4, 4, 16'h5000, 16'h0001);
        wait_ready("R2 ready small wave");
        run_check(4, 16'h5000, 16'h0001, "pre");
        send(C_DAT, 16'hDEAD);
        chk("R10 data during play sets cmd_err", 32'(cmd_err), 32'd1);
        send(C_CNT, 16'd7);
        chk("R11 count during play keeps playing", 32'(playing), 32'd1);
        chk("R11 count during play sets cmd_err", 32'(cmd_err), 32'd1);
        do_stop();
        wait_ready("R8 ready after stop");
        run_check(4, 16'h5000, 16'h0001, "R8 R10 R11 replay");
        do_stop();
        wait_ready("R8 ready again");

        // R10 data beyond the count
        load(4, 4, 16'h6000, 16'h0002);
        wait_ready("R2 reload");
        chk("R2 count command clears cmd_err", 32'(cmd_err), 32'd0);
        send(C_DAT, 16'hBEEF);
        chk("R10 extra data sets cmd_err", 32'(cmd_err), 32'd1);
        run_check(4, 16'h6000, 16'h0002, "R10 extra discarded");
        do_stop();

        // R9 zero count after data was loaded
        send(C_CNT, 16'd0);
        repeat (40) @(negedge clk);
        send(C_TRG, 16'h0);
        repeat (10) @(negedge clk);
        chk("R9 zero count trigger ignored", 32'(playing), 32'd0);
        chk("R9 not ready at zero count", 32'(ready), 32'd0);

        // R7 underrun with a sample clock faster than the system clock
        load(20, 20, 16'h7000, 16'h0003);
        wait_ready("R3 ready before underrun");
        smp_half = 2;
        send(C_TRG, 16'h0);
        repeat (300) @(negedge clk);
        chk("R7 underrun raised", 32'(underrun), 32'd1);
        do_stop();
        smp_half = 20;
        load(20, 20, 16'h9000, 16'h0005);
        wait_ready("R8 ready after underrun");
        chk("R7 underrun sticky until trigger", 32'(underrun), 32'd1);
        run_check(20, 16'h9000, 16'h0005, "R7 after underrun");
        chk("R7 underrun cleared by trigger", 32'(underrun), 32'd0);
        do_stop();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule